// File: doc/BRIEF.md
# Framed four-bit pattern detector

This block watches a single serial bit stream and raises a flag when a four-bit frame matches one of two accepted words. Frames do not overlap. The first four valid samples after reset form one frame, the next four form the following frame, and so on. A match that straddles a frame boundary is never reported.

The output is Mealy style. It is computed from the position in the frame, the bits already held and the bit on the input in the same cycle. The flag is therefore high during the cycle in which the last bit of a matching frame is offered, and goes low again at once.

A sample-qualify input selects which clock cycles carry a data bit. Cycles with the qualifier low leave the frame untouched. A synchronous reset restarts framing at the first bit.

The frame length, the number of accepted words and the words themselves are parameters. A further parameter chooses how matching is built: per-word running flags, or a shift register compared against the words at the end of the frame.

Top module: `frame_pattern_det`

## Requirements
- R1: While `rst` is high at a rising edge, the detector returns to the frame start. With `smp_en` low after reset, `z_out` is 0.
- R2: `z_out` is 0 during the first, second and third valid samples of every frame.
- R3: On the fourth valid sample of a frame, `z_out` is 1 exactly when the four bits, written with the earliest bit leftmost, equal 0101 or 1001. The fourth bit is the one present on `x_in` in that cycle.
- R4: Frames do not overlap. After the fourth valid sample the next valid sample is bit one of a new frame, so a match that spans two frames gives `z_out` = 0.
- R5: A frame that can no longer match still takes exactly four valid samples. The frame after it is detected normally.
- R6: A cycle with `smp_en` low is not a sample. `z_out` is 0 in that cycle, and the frame position and held bits do not change.
- R7: A reset applied in the middle of a frame discards the partial frame. The next valid sample is treated as bit one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | High when the current cycle carries a valid sample |
| x_in | input | 1 | Serial data bit |
| z_out | output | 1 | Match flag, valid in the cycle of the fourth sample |

## Verification
The bench goes after the frame boundary. A design that searched a sliding window would flag 0101 when it spans two frames. A design that ended a frame early after a mismatch would misalign every frame that follows.

The bench leaves gaps with the qualifier low. A design that counted idle cycles, or let the flag through while idle, would then report hits in the wrong cycles.

A reset in the middle of a frame is checked, since a design that kept the old partial frame would miss the next match. All sixteen possible frames are driven to catch a wrong word, bit order or registered output.

// File: rtl/frame_det_pkg.sv
package frame_det_pkg;

   typedef enum logic {
      MATCH_FLAGS = 1'b0,
      MATCH_SHIFT = 1'b1
   } match_style_e;

   localparam int unsigned DEF_FRAME_LEN = 4;
   localparam int unsigned DEF_NUM_PAT   = 2;
   // word i sits at [i*FRAME_LEN +: FRAME_LEN]; MSB is the earliest bit
   localparam logic [7:0]  DEF_PATTERNS  = {4'b1001, 4'b0101};

   function automatic int unsigned pos_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/frame_pos_counter.sv
module frame_pos_counter #(
   parameter int unsigned FRAME_LEN = 4,
   parameter int unsigned POS_W     = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   output logic [POS_W-1:0] pos_q,
   output logic             first_o,
   output logic             last_o
);

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

   initial begin
      assert (FRAME_LEN >= 2) else $error("frame_pos_counter: FRAME_LEN below 2");
      assert ((1 << POS_W) >= FRAME_LEN) else $error("frame_pos_counter: POS_W too small");
   end

   assign first_o = (pos_q == '0);
   assign last_o  = (pos_q == LAST_POS);

   always_ff @(posedge clk) begin
      if (rst)         pos_q <= '0;
      else if (en) begin
         if (last_o)   pos_q <= '0;
         else          pos_q <= pos_q + 1'b1;
      end
   end

   p_reset_to_start_r7: assert property (@(posedge clk) rst |=> (pos_q == '0));

   p_pos_in_range_r5: assert property (@(posedge clk) disable iff (rst)
      (pos_q <= LAST_POS));

   p_wrap_after_last_r4: assert property (@(posedge clk) disable iff (rst)
      (en && last_o) |=> (pos_q == '0));

   p_idle_holds_r6: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(pos_q));

endmodule

// File: rtl/frame_flag_tracker.sv
module frame_flag_tracker #(
   parameter int unsigned                       FRAME_LEN = 4,
   parameter int unsigned                       NUM_PAT   = 2,
   parameter logic [NUM_PAT*FRAME_LEN-1:0]      PATTERNS  = '0,
   parameter int unsigned                       POS_W     = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             x_i,
   input  logic [POS_W-1:0] pos_i,
   input  logic             first_i,
   input  logic             last_i,
   output logic             hit_o,
   output logic             fail_o
);

   logic [NUM_PAT-1:0] alive_q;
   logic [NUM_PAT-1:0] alive_eff;
   logic [NUM_PAT-1:0] bit_ok;

   for (genvar i = 0; i < NUM_PAT; i++) begin : g_word
      logic [FRAME_LEN-1:0] pat_rev;
      for (genvar p = 0; p < FRAME_LEN; p++) begin : g_bit
         assign pat_rev[p] = PATTERNS[i*FRAME_LEN + FRAME_LEN - 1 - p];
      end
      assign bit_ok[i] = ~(x_i ^ pat_rev[pos_i]);
   end

   assign alive_eff = first_i ? '1 : alive_q;
   assign hit_o     = |(alive_eff & bit_ok);
   assign fail_o    = ~|alive_eff;

   always_ff @(posedge clk) begin
      if (rst)     alive_q <= '1;
      else if (en) alive_q <= alive_eff & bit_ok;
   end

   // once no word can match, the frame stays on the fail path until its end
   p_fail_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      (en && !last_i && fail_o) |=> fail_o);

   p_flags_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(alive_q));

endmodule

// File: rtl/frame_shift_matcher.sv
module frame_shift_matcher #(
   parameter int unsigned                  FRAME_LEN = 4,
   parameter int unsigned                  NUM_PAT   = 2,
   parameter logic [NUM_PAT*FRAME_LEN-1:0] PATTERNS  = '0
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic x_i,
   output logic hit_o
);

   logic [FRAME_LEN-2:0] sh_q;
   logic [FRAME_LEN-1:0] word;
   logic [NUM_PAT-1:0]   eq;

   assign word = {sh_q, x_i};

   for (genvar i = 0; i < NUM_PAT; i++) begin : g_cmp
      assign eq[i] = (word == PATTERNS[i*FRAME_LEN +: FRAME_LEN]);
   end

   assign hit_o = |eq;

   always_ff @(posedge clk) begin
      if (rst)     sh_q <= '0;
      else if (en) sh_q <= word[FRAME_LEN-2:0];
   end

   p_shift_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(sh_q));

endmodule

// File: rtl/frame_pattern_det.sv
module frame_pattern_det
   import frame_det_pkg::*;
#(
   parameter int unsigned                  FRAME_LEN   = DEF_FRAME_LEN,
   parameter int unsigned                  NUM_PAT     = DEF_NUM_PAT,
   parameter logic [NUM_PAT*FRAME_LEN-1:0] PATTERNS    = DEF_PATTERNS,
   parameter match_style_e                 MATCH_STYLE = MATCH_FLAGS
) (
   input  logic clk,
   input  logic rst,
   input  logic smp_en,
   input  logic x_in,
   output logic z_out
);

   localparam int unsigned POS_W = pos_width(FRAME_LEN);

   initial begin
      assert (FRAME_LEN >= 2) else $error("frame_pattern_det: FRAME_LEN below 2");
      assert (NUM_PAT >= 1)   else $error("frame_pattern_det: NUM_PAT is 0");
   end

   logic [POS_W-1:0] pos;
   logic             at_first;
   logic             at_last;
   logic             hit;

   frame_pos_counter #(
      .FRAME_LEN (FRAME_LEN),
      .POS_W     (POS_W)
   ) u_pos (
      .clk     (clk),
      .rst     (rst),
      .en      (smp_en),
      .pos_q   (pos),
      .first_o (at_first),
      .last_o  (at_last)
   );

   if (MATCH_STYLE == MATCH_FLAGS) begin : g_flags
      logic fail;
      frame_flag_tracker #(
         .FRAME_LEN (FRAME_LEN),
         .NUM_PAT   (NUM_PAT),
         .PATTERNS  (PATTERNS),
         .POS_W     (POS_W)
      ) u_match (
         .clk     (clk),
         .rst     (rst),
         .en      (smp_en),
         .x_i     (x_in),
         .pos_i   (pos),
         .first_i (at_first),
         .last_i  (at_last),
         .hit_o   (hit),
         .fail_o  (fail)
      );
      p_fail_no_z_r5: assert property (@(posedge clk) disable iff (rst)
         fail |-> !z_out);
   end else begin : g_shift
      frame_shift_matcher #(
         .FRAME_LEN (FRAME_LEN),
         .NUM_PAT   (NUM_PAT),
         .PATTERNS  (PATTERNS)
      ) u_match (
         .clk   (clk),
         .rst   (rst),
         .en    (smp_en),
         .x_i   (x_in),
         .hit_o (hit)
      );
   end

   assign z_out = smp_en & at_last & hit;

   p_z_then_start_r4: assert property (@(posedge clk) disable iff (rst)
      z_out |=> at_first);

endmodule

// File: tb/frame_pattern_det_tb_top.sv
module frame_pattern_det_tb_top;
   import frame_det_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic smp_en = 1'b0;
   logic x_in = 1'b0;
   logic z_out, z_alt;

   int checks = 0;
   int errors = 0;
   int m_pos = 0;
   logic [3:0] m_bits = '0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frame_pattern_det dut_i (
      .clk(clk), .rst(rst), .smp_en(smp_en), .x_in(x_in), .z_out(z_out));

   frame_pattern_det #(.MATCH_STYLE(MATCH_SHIFT)) dut_alt_i (
      .clk(clk), .rst(rst), .smp_en(smp_en), .x_in(x_in), .z_out(z_alt));

   function automatic logic exp_z(input int pos, input logic [3:0] bits,
                                  input logic e, input logic b);
      logic [3:0] w;
      w = {bits[2:0], b};
      return e && (pos == 3) && (w == 4'b0101 || w == 4'b1001);
   endfunction

   task automatic check(input string tag, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: z=%b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic step(input logic e, input logic b, input string tag);
      logic ez;
      string t;
      @(negedge clk);
      smp_en = e;
      x_in = b;
      #1;
      ez = exp_z(m_pos, m_bits, e, b);
      t = tag;
      if (t == "") t = !e ? "R6" : (m_pos < 3 ? "R2" : "R3");
      check(t, z_out, ez);
      check({t, " alt"}, z_alt, ez);
      @(posedge clk);
      if (e) begin
         if (m_pos == 3) m_pos = 0;
         else begin
            m_bits = {m_bits[2:0], b};
            m_pos++;
         end
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      smp_en = 1'b0;
      @(posedge clk);
      m_pos = 0;
      @(negedge clk);
      rst = 1'b0;
      #1;
      check("R1", z_out, 1'b0);
      check("R1 alt", z_alt, 1'b0);
   endtask

   task automatic frame(input logic [3:0] w, input string last_tag);
      for (int k = 3; k >= 0; k--) step(1'b1, w[k], (k == 0) ? last_tag : "");
   endtask

   initial begin
      repeat (2) @(posedge clk);
      do_reset();

      // every frame value, first bit leftmost (R3)
      for (int v = 0; v < 16; v++) frame(4'(v), "R3");

      // match across a frame boundary must not be flagged (R4)
      frame(4'b1010, "R4");
      step(1'b1, 1'b1, "R4");
      step(1'b1, 1'b0, "R4");
      step(1'b1, 1'b0, "R4");
      step(1'b1, 1'b0, "R4");

      // early mismatch still consumes four samples (R5)
      frame(4'b1111, "R5");
      frame(4'b0101, "R5");
      frame(4'b0011, "R5");
      frame(4'b1001, "R5");

      // idle gaps inside a frame (R6)
      step(1'b1, 1'b0, "");
      step(1'b0, 1'b1, "R6");
      step(1'b1, 1'b1, "");
      step(1'b0, 1'b0, "R6");
      step(1'b0, 1'b1, "R6");
      step(1'b1, 1'b0, "");
      step(1'b0, 1'b1, "R6");
      step(1'b1, 1'b1, "R6");

      // reset mid-frame discards partial bits (R7)
      step(1'b1, 1'b1, "");
      step(1'b1, 1'b0, "");
      do_reset();
      frame(4'b0101, "R7");

      // constrained random stream
      void'($urandom(32'h5eed_0042));
      for (int n = 0; n < 4000; n++)
         step(($urandom % 10) < 8, $urandom % 2, "");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule